// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block holds a programmable list of conversion settings for a multiplexed 16-bit ADC front end. Each list entry names an input channel, a gain code, an input range and an input mode. During an acquisition every conversion-started strobe moves the block to the next entry. The current entry's fields drive the analog multiplexer and the gain stage. Channels can therefore be visited in any order, at any gain, and as often as needed.

A simple write port loads the entries and the list length while the block is idle. An acquisition-active level comes from the trigger logic elsewhere. Its rising edge returns the sequencer to the head of the list. An end-of-scan pulse marks each pass through the whole list.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the entry index is 0, the list length is 1, every entry reads as all zeros and end_of_scan is low.
- R2: A length write with a value from 1 to 176 is accepted while idle and also returns the index to 0. The values 0 and any value above 176 are ignored.
- R3: An entry byte is packed as follows. Bits 3:0 hold the channel and bits 5:4 hold the gain code. Bit 6 holds the range, where 1 means 0 to 10 V unipolar and 0 means ±10 V bipolar. Bit 7 holds the mode, where 1 means differential and 0 means single-ended. A write to an address of 176 or above is ignored.
- R4: An entry write with differential mode and a channel above 7 (bit 3 set) is ignored, and the stored entry is left unchanged.
- R5: Entry writes and length writes are ignored while acq_active is high.
- R6: In the cycle after acq_active rises, the index is 0, whatever conv_start was doing.
- R7: While acq_active is high (and not on its first cycle), each conv_start cycle advances the index by one. The output fields always show the entry at the current index.
- R8: A conv_start on the last entry (index = length-1) wraps the index to 0. end_of_scan is then high for exactly the following cycle. With length 1, end_of_scan is high after every conv_start.
- R9: conv_start while acq_active is low has no effect on the index or on end_of_scan.
- R10: Entries are independent, so the same channel may appear in several positions with different gain, range or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_active | input | 1 | Acquisition in progress (level) |
| conv_start | input | 1 | One-cycle strobe: a conversion has started |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_addr | input | 8 | Entry address |
| ent_wr_data | input | 8 | Packed entry (see R3) |
| len_wr_en | input | 1 | Length write strobe |
| len_wr_data | input | 8 | List length, 1 to 176 |
| entry_idx | output | 8 | Current entry index |
| chan_sel | output | 4 | Channel of current entry |
| gain_sel | output | 2 | Gain code of current entry |
| range_unipolar | output | 1 | 1 = 0..10 V, 0 = ±10 V |
| diff_mode | output | 1 | 1 = differential input |
| end_of_scan | output | 1 | One-cycle pulse after the list wraps |

## Verification
The assertions assume that conv_start is a strobe that matters only while acq_active is high. They also assume that the list contents are frozen for the whole of an acquisition. The stimulus keeps to this model: it writes the list only between acquisitions, and it also tries writes during an acquisition, which must be ignored. conv_start pulses arrive both back to back and with gaps. Some land in the first cycle of an acquisition, and some land while the block is idle. This lets the restart and no-effect cases, as well as wraps at lengths 1, 4 and 176, be compared against a behavioural model on every clock.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int CHAN_W = 4;
  localparam int GAIN_W = 2;

  typedef struct packed {
    logic              diff;
    logic              unipolar;
    logic [GAIN_W-1:0] gain;
    logic [CHAN_W-1:0] chan;
  } scan_entry_t;

  localparam int ENTRY_W = $bits(scan_entry_t);

  // differential inputs pair channels, so only the lower half exists
  function automatic logic entry_legal(scan_entry_t e);
    return !(e.diff && e.chan[CHAN_W-1]);
  endfunction
endpackage

// File: rtl/scan_list_store.sv
module scan_list_store
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 176,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_active,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  scan_entry_t   wr_data,
  input  logic [AW-1:0] rd_idx,
  output scan_entry_t   rd_entry
);
  localparam logic [AW-1:0] DEPTH_V = AW'(DEPTH);

  scan_entry_t                mem_q [DEPTH];
  logic [DEPTH*ENTRY_W-1:0]   mem_flat;
  logic                       wr_accept;

  assign wr_accept = wr_en && !acq_active && (wr_addr < DEPTH_V) && entry_legal(wr_data);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem_q[i] <= '0;
      else if (wr_accept && wr_addr == AW'(i))     mem_q[i] <= wr_data;
    end
    assign mem_flat[i*ENTRY_W +: ENTRY_W] = mem_q[i];
  end

  always_comb begin
    rd_entry = '0;
    if (rd_idx < DEPTH_V) rd_entry = mem_q[rd_idx];
  end

  // R5
  frozen_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_active |=> $stable(mem_flat));
  // R4
  diff_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_entry.diff |-> (rd_entry.chan < 4'd8));
endmodule

// File: rtl/scan_pointer.sv
module scan_pointer #(
  parameter int DEPTH = 176,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_active,
  input  logic          conv_start,
  input  logic          len_wr_en,
  input  logic [AW-1:0] len_wr_data,
  output logic [AW-1:0] idx,
  output logic          end_of_scan
);
  localparam logic [AW-1:0] DEPTH_V = AW'(DEPTH);

  logic [AW-1:0] len_q;
  logic          acq_q;
  logic          acq_start, len_accept, advance, wrap_evt;

  function automatic logic [AW-1:0] step_idx(logic [AW-1:0] cur, logic [AW-1:0] len);
    return (cur == len - AW'(1)) ? '0 : cur + AW'(1);
  endfunction

  assign acq_start  = acq_active && !acq_q;
  assign len_accept = len_wr_en && !acq_active &&
                      (len_wr_data != '0) && (len_wr_data <= DEPTH_V);
  assign advance    = acq_active && !acq_start && conv_start;
  assign wrap_evt   = advance && (idx == len_q - AW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q       <= AW'(1);
      idx         <= '0;
      acq_q       <= 1'b0;
      end_of_scan <= 1'b0;
    end else begin
      acq_q       <= acq_active;
      end_of_scan <= wrap_evt;
      if (len_accept) len_q <= len_wr_data;
      if (acq_start || len_accept) idx <= '0;
      else if (advance)            idx <= step_idx(idx, len_q);
    end
  end

  // R8
  idx_in_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx < len_q);
  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (len_q <= DEPTH_V));
  // R6
  restart_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> (idx == '0));
  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap_evt) |=> (idx == $past(idx) + AW'(1)));
  // R8
  eos_at_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_scan |-> (idx == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_active && !len_accept) |=> ($stable(idx) && !end_of_scan));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 176,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acq_active,
  input  logic                conv_start,
  input  logic                ent_wr_en,
  input  logic [AW-1:0]       ent_wr_addr,
  input  logic [ENTRY_W-1:0]  ent_wr_data,
  input  logic                len_wr_en,
  input  logic [AW-1:0]       len_wr_data,
  output logic [AW-1:0]       entry_idx,
  output logic [CHAN_W-1:0]   chan_sel,
  output logic [GAIN_W-1:0]   gain_sel,
  output logic                range_unipolar,
  output logic                diff_mode,
  output logic                end_of_scan
);
  scan_entry_t cur_entry;
  logic [AW-1:0] idx_w;

  scan_pointer #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .acq_active(acq_active), .conv_start(conv_start),
    .len_wr_en(len_wr_en), .len_wr_data(len_wr_data),
    .idx(idx_w), .end_of_scan(end_of_scan)
  );

  scan_list_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .acq_active(acq_active),
    .wr_en(ent_wr_en), .wr_addr(ent_wr_addr), .wr_data(scan_entry_t'(ent_wr_data)),
    .rd_idx(idx_w), .rd_entry(cur_entry)
  );

  assign entry_idx      = idx_w;
  assign chan_sel       = cur_entry.chan;
  assign gain_sel       = cur_entry.gain;
  assign range_unipolar = cur_entry.unipolar;
  assign diff_mode      = cur_entry.diff;
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  logic clk = 0, rst_n = 0;
  logic acq_active = 0, conv_start = 0, ent_wr_en = 0, len_wr_en = 0;
  logic [7:0] ent_wr_addr = 0, ent_wr_data = 0, len_wr_data = 0;
  logic [7:0] entry_idx;
  logic [3:0] chan_sel;
  logic [1:0] gain_sel;
  logic range_unipolar, diff_mode, end_of_scan;

  always #4 clk = ~clk;

  adc_scan_seq dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  int m_len = 1, m_ptr = 0;
  bit m_acq_q = 0, m_eos = 0;
  int m_mem [176];

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each edge from the inputs set half a cycle before
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_len = 1; m_ptr = 0; m_acq_q = 0; m_eos = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else begin
      bit start;
      start = acq_active && !m_acq_q;
      m_eos = 0;
      if (!acq_active) begin
        if (ent_wr_en && ent_wr_addr < 176 && !(ent_wr_data[7] && ent_wr_data[3]))
          m_mem[ent_wr_addr] = ent_wr_data;
        if (len_wr_en && len_wr_data >= 1 && len_wr_data <= 176) begin
          m_len = len_wr_data; m_ptr = 0;
        end
      end
      if (start) m_ptr = 0;
      else if (acq_active && conv_start) begin
        if (m_ptr == m_len - 1) begin m_ptr = 0; m_eos = 1; end
        else m_ptr++;
      end
      m_acq_q = acq_active;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(entry_idx, m_ptr, "R7 index");
    chk({diff_mode, range_unipolar, gain_sel, chan_sel}, m_mem[m_ptr], "R7 R3 fields");
    chk(end_of_scan, m_eos, "R8 end_of_scan");
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr_ent(input int a, input int d);
    ent_wr_en = 1; ent_wr_addr = 8'(a); ent_wr_data = 8'(d); tick(); ent_wr_en = 0;
  endtask
  task automatic wr_len(input int l);
    len_wr_en = 1; len_wr_data = 8'(l); tick(); len_wr_en = 0;
  endtask
  task automatic conv(input int gap);
    conv_start = 1; tick(); conv_start = 0;
    repeat (gap) tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk(entry_idx, 0, "R1 idx");
    chk({diff_mode, range_unipolar, gain_sel, chan_sel}, 0, "R1 fields");
    chk(end_of_scan, 0, "R1 eos");

    // R10: channel 5 twice with different settings, R3 packing
    wr_ent(0, 8'h65);   // ch5, gain2, unipolar, single-ended
    wr_ent(1, 8'h05);   // ch5, gain0, bipolar
    wr_ent(2, 8'h93);   // ch3, gain1, differential
    wr_ent(3, 8'h3C);   // ch12, gain3, single-ended
    wr_ent(3, 8'h89);   // R4: differential ch9 rejected
    wr_ent(200, 8'h11); // R3: out-of-range address ignored
    wr_len(0);          // R2 ignored
    wr_len(200);        // R2 ignored
    wr_len(4);
    tick();
    chk(entry_idx, 0, "R2 idx after len write");

    // R9: conv while idle
    conv(1);
    chk(entry_idx, 0, "R9 idle conv");

    // R6: conv on first active cycle does not advance
    acq_active = 1; conv_start = 1; tick(); conv_start = 0;
    chk(entry_idx, 0, "R6 restart");
    conv(0); chk(chan_sel, 5, "R10 dup ch"); chk(gain_sel, 0, "R10 gain");
    conv(2); chk(chan_sel, 3, "R3 ch"); chk(diff_mode, 1, "R3 diff");
    conv(0); chk(chan_sel, 12, "R4 entry kept");
    // R5: writes during acquisition
    wr_ent(0, 8'h0F); wr_len(2);
    conv(0);
    chk(end_of_scan, 1, "R8 wrap pulse"); chk(entry_idx, 0, "R8 wrap idx");
    chk(range_unipolar, 1, "R5 entry0 kept");
    tick(); chk(end_of_scan, 0, "R8 one cycle");
    repeat (9) conv(1);
    conv(0); conv(0); conv(0);
    acq_active = 0; tick();
    conv(0);

    // R6 restart from mid-list
    acq_active = 1; tick(); conv(0); conv(0);
    acq_active = 0; tick();
    acq_active = 1; tick();
    chk(entry_idx, 0, "R6 mid-list restart");
    acq_active = 0; tick();

    // R8 length 1: pulse on every conv
    wr_len(1);
    acq_active = 1; tick();
    repeat (5) conv(0);
    conv(2);
    acq_active = 0; tick();

    // full list of 176
    for (int i = 0; i < 176; i++) wr_ent(i, (i * 37 + 11) & 8'h7F);
    wr_len(176);
    acq_active = 1; tick();
    for (int i = 0; i < 180; i++) conv(i % 3 == 0 ? 1 : 0);
    acq_active = 0; tick(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule